// File: doc/BRIEF.md
# Dual-Bridge Rotated-State Gate Sequencer

This block sits between a conventional three-phase PWM modulator and the gate drivers of a dual inverter built from two full bridges whose outputs feed the two ends of a set of transformer windings. The modulator drives the first bridge directly. The sequencer derives the gates of the second bridge by rotating the phase order of the first bridge's upper and lower gate vectors. Both bridges therefore hold the same number of upper switches on at every instant, so the common-mode voltage seen at the windings cancels. Shoot-through intervals pass through the same combinational rotation, so they begin and end on the same clock edge in both bridges and last equally long.

The block also produces the gates of the series switches that connect each DC source to its impedance network. A source switch opens whenever a leg it feeds is shorted, and it stays open permanently when the converter is set for one-way power flow. A fault code can clamp the second bridge into a fixed state while the first bridge keeps modulating. The rotation direction, the fault code, the single/dual-source selection and the one-way selection are captured only on a carrier-period strobe, so a change never lands in the middle of a switching period.

Top module: `dzs_gate_seq`

## Requirements
- R1: After reset the captured settings are rotation direction 0, no fault, single source and bidirectional, and these stay in force until the first strobe.
- R2: With direction 0, phase B of bridge 2 takes phase A of bridge 1, C takes B, and A takes C. Gate vectors put phase A at bit 2 and phase C at bit 0, so upper {100} gives {010}. The same mapping applies to the lower gates.
- R3: With direction 1, phase A of bridge 2 takes phase B of bridge 1, B takes C, and C takes A, so upper {100} gives {001}.
- R4: When no fault is set, bridge 2 has a shorted leg in exactly the cycles in which bridge 1 has one, with no added delay.
- R5: When no fault is set, bridge 2 is never in the all-lower null state while bridge 1 is in the all-upper null state.
- R6: The first source-switch gate is low whenever a leg of bridge 1 has both gates on, and also, in single-source mode, whenever a leg of bridge 2 has both gates on. Otherwise it is high.
- R7: With one-way operation selected, both source-switch gates are held low.
- R8: Fault code 01 (upper-switch open) forces bridge 2 to upper 000 and lower 111.
- R9: Fault code 10 (upper-switch short) forces bridge 2 to upper 111 and lower 000.
- R10: Fault code 11 (double fault) in dual-source mode turns on both gates of leg A of bridge 2 and turns off both gates of the other legs. In single-source mode, fault code 11 acts as fault code 01.
- R11: In dual-source mode the second source-switch gate is low when a leg of bridge 2 has both gates on, and high otherwise. In single-source mode it is always low.
- R12: Changes on the direction, fault, source-mode and one-way inputs have no effect until a cycle in which the period strobe is high. From the next cycle onward the new values apply.
- R13: When no fault is set, the number of upper gates on in bridge 1 equals the number on in bridge 2, so the phase voltages sum to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_strobe | input | 1 | Carrier-period strobe; captures the settings |
| b1_hi | input | 3 | Bridge 1 upper gates (bit 2 = phase A) |
| b1_lo | input | 3 | Bridge 1 lower gates (bit 2 = phase A) |
| dir_sel | input | 1 | Rotation direction (0 or 1) |
| fault_code | input | 2 | 00 none, 01 open, 10 short, 11 double |
| dual_src | input | 1 | 1 = two isolated sources |
| one_way | input | 1 | 1 = one-way power flow, source switches held off |
| b2_hi | output | 3 | Bridge 2 upper gates |
| b2_lo | output | 3 | Bridge 2 lower gates |
| src1_gate | output | 1 | Gate of the series switch for source 1 |
| src2_gate | output | 1 | Gate of the series switch for source 2 |

## Verification
The assertions place no restriction on the primary gate vectors: any pattern of upper and lower gates is legal, including dead-band and shorted legs. They do assume that the strobe and the setting inputs are synchronous to the clock, and the stimulus changes them only at falling edges. The stimulus sweeps every one of the 64 gate patterns under every captured setting, so the rotation, shoot-through and clamp properties are exercised with each input shape. The assertions that need the fault-free case are qualified by the captured fault code rather than by the raw input. Between strobes the raw inputs can differ from the captured settings, and the bench drives them that way on purpose.

// File: rtl/dzs_pkg.sv
package dzs_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_OPEN   = 2'b01,
    FLT_SHORT  = 2'b10,
    FLT_DOUBLE = 2'b11
  } flt_e;

  typedef struct packed {
    logic dir;
    flt_e flt;
    logic dual;
    logic oneway;
  } seq_cfg_t;

  localparam seq_cfg_t CFG_RESET = '{dir: 1'b0, flt: FLT_NONE, dual: 1'b0, oneway: 1'b0};

endpackage

// File: rtl/dzs_cfg_latch.sv
module dzs_cfg_latch
  import dzs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe,
  input  seq_cfg_t cfg_in,
  output seq_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (strobe) cfg_q <= cfg_in;
  end

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cfg_q));

  // R12
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (cfg_q == $past(cfg_in)));

endmodule

// File: rtl/dzs_rotator.sv
module dzs_rotator #(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir,
  input  logic [NPH-1:0] in_hi,
  input  logic [NPH-1:0] in_lo,
  output logic [NPH-1:0] out_hi,
  output logic [NPH-1:0] out_lo
);

  localparam int unsigned STEP_FWD = 1;
  localparam int unsigned STEP_REV = NPH - 1;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    localparam int unsigned SRC_FWD = (i + STEP_FWD) % NPH;
    localparam int unsigned SRC_REV = (i + STEP_REV) % NPH;
    assign out_hi[i] = dir ? in_hi[SRC_REV] : in_hi[SRC_FWD];
    assign out_lo[i] = dir ? in_lo[SRC_REV] : in_lo[SRC_FWD];
  end

  // R13
  rot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_hi) == $countones(in_hi));

  // R4
  rot_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_hi & out_lo)) == (|(in_hi & in_lo)));

endmodule

// File: rtl/dzs_fault_clamp.sv
module dzs_fault_clamp
  import dzs_pkg::*;
#(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  flt_e           flt,
  input  logic           dual,
  input  logic [NPH-1:0] rot_hi,
  input  logic [NPH-1:0] rot_lo,
  output logic [NPH-1:0] b2_hi,
  output logic [NPH-1:0] b2_lo,
  output logic           clamp_on
);

  localparam int unsigned LEG_A = NPH - 1;
  localparam logic [NPH-1:0] LEG_A_MASK = {1'b1, {(NPH-1){1'b0}}};

  flt_e eff_flt;

  always_comb begin
    eff_flt = flt;
    if (flt == FLT_DOUBLE && !dual) eff_flt = FLT_OPEN;
  end

  always_comb begin
    b2_hi = rot_hi;
    b2_lo = rot_lo;
    unique case (eff_flt)
      FLT_NONE:   begin b2_hi = rot_hi;      b2_lo = rot_lo;      end
      FLT_OPEN:   begin b2_hi = '0;          b2_lo = '1;          end
      FLT_SHORT:  begin b2_hi = '1;          b2_lo = '0;          end
      FLT_DOUBLE: begin b2_hi = LEG_A_MASK;  b2_lo = LEG_A_MASK;  end
      default:    begin b2_hi = '0;          b2_lo = '1;          end
    endcase
  end

  assign clamp_on = (eff_flt != FLT_NONE);

  // R8
  open_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt == FLT_OPEN) |-> (b2_hi == '0 && b2_lo == '1));

  // R9
  short_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt == FLT_SHORT) |-> (b2_hi == '1 && b2_lo == '0));

  // R10
  dbl_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt == FLT_DOUBLE && dual) |-> (b2_hi[LEG_A] && b2_lo[LEG_A] && $countones(b2_hi) == 1));

endmodule

// File: rtl/dzs_src_gate.sv
module dzs_src_gate #(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] b1_hi,
  input  logic [NPH-1:0] b1_lo,
  input  logic [NPH-1:0] b2_hi,
  input  logic [NPH-1:0] b2_lo,
  input  logic           dual,
  input  logic           oneway,
  output logic           src1,
  output logic           src2
);

  function automatic logic leg_shorted(input logic [NPH-1:0] hi, input logic [NPH-1:0] lo);
    return |(hi & lo);
  endfunction

  logic st_b1, st_b2;
  assign st_b1 = leg_shorted(b1_hi, b1_lo);
  assign st_b2 = leg_shorted(b2_hi, b2_lo);

  always_comb begin
    if (oneway) begin
      src1 = 1'b0;
      src2 = 1'b0;
    end else if (dual) begin
      src1 = !st_b1;
      src2 = !st_b2;
    end else begin
      src1 = !(st_b1 || st_b2);
      src2 = 1'b0;
    end
  end

  // R6
  src1_st_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(b1_hi & b1_lo)) |-> !src1);

  // R7
  oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oneway |-> (!src1 && !src2));

  // R11
  src2_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual |-> !src2);

endmodule

// File: rtl/dzs_gate_seq.sv
module dzs_gate_seq
  import dzs_pkg::*;
#(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           period_strobe,
  input  logic [NPH-1:0] b1_hi,
  input  logic [NPH-1:0] b1_lo,
  input  logic           dir_sel,
  input  logic [1:0]     fault_code,
  input  logic           dual_src,
  input  logic           one_way,
  output logic [NPH-1:0] b2_hi,
  output logic [NPH-1:0] b2_lo,
  output logic           src1_gate,
  output logic           src2_gate
);

  seq_cfg_t cfg_in, cfg_q;
  logic [NPH-1:0] rot_hi, rot_lo;
  logic clamp_on;

  assign cfg_in = '{dir: dir_sel, flt: flt_e'(fault_code), dual: dual_src, oneway: one_way};

  dzs_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .strobe(period_strobe),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  dzs_rotator #(.NPH(NPH)) u_rot (
    .clk(clk), .rst_n(rst_n), .dir(cfg_q.dir),
    .in_hi(b1_hi), .in_lo(b1_lo), .out_hi(rot_hi), .out_lo(rot_lo)
  );

  dzs_fault_clamp #(.NPH(NPH)) u_clamp (
    .clk(clk), .rst_n(rst_n), .flt(cfg_q.flt), .dual(cfg_q.dual),
    .rot_hi(rot_hi), .rot_lo(rot_lo), .b2_hi(b2_hi), .b2_lo(b2_lo),
    .clamp_on(clamp_on)
  );

  dzs_src_gate #(.NPH(NPH)) u_src (
    .clk(clk), .rst_n(rst_n),
    .b1_hi(b1_hi), .b1_lo(b1_lo), .b2_hi(b2_hi), .b2_lo(b2_lo),
    .dual(cfg_q.dual), .oneway(cfg_q.oneway),
    .src1(src1_gate), .src2(src2_gate)
  );

  // R5
  null_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp_on && b1_hi == '1 && b1_lo == '0) |-> !(b2_hi == '0 && b2_lo == '1));

  // R4
  st_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_on |-> ((|(b1_hi & b1_lo)) == (|(b2_hi & b2_lo))));

  // R13
  cm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_on |-> ($countones(b1_hi) == $countones(b2_hi)));

endmodule

// File: tb/dzs_gate_seq_bench.sv
`timescale 1ns/1ps
module dzs_gate_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [2:0] hi = 3'b000, lo = 3'b111;
  logic dir = 1'b0;
  logic [1:0] flt = 2'b00;
  logic dual = 1'b0, ow = 1'b0;
  logic [2:0] o_hi, o_lo;
  logic s1, s2;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dzs_gate_seq u_dzs_gate_seq (
    .clk(clk), .rst_n(rst_n), .period_strobe(strobe),
    .b1_hi(hi), .b1_lo(lo), .dir_sel(dir), .fault_code(flt),
    .dual_src(dual), .one_way(ow),
    .b2_hi(o_hi), .b2_lo(o_lo), .src1_gate(s1), .src2_gate(s2)
  );

  // direction 0: A->B, B->C, C->A ; direction 1: B->A, C->B, A->C
  function automatic logic [2:0] turn(input logic d, input logic [2:0] v);
    if (!d) return (v >> 1) | ((v & 3'd1) << 2);
    return ((v << 1) & 3'd7) | (v >> 2);
  endfunction

  function automatic int ones(input logic [2:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (hi=%b lo=%b dir=%0d flt=%0d dual=%0d ow=%0d)",
               req, got, exp, hi, lo, dir, flt, dual, ow);
    end
  endtask

  task automatic load_cfg(input logic d, input logic [1:0] f, input logic du, input logic o);
    @(negedge clk);
    dir = d; flt = f; dual = du; ow = o; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  // Expected outputs from the captured settings (cd, cf, cdu, co)
  task automatic check_vec(input logic cd, input logic [1:0] cf, input logic cdu, input logic co, input string tag);
    logic [2:0] eh, el;
    logic st1, st2, e1, e2;
    logic [1:0] ef;
    ef = (cf == 2'd3 && !cdu) ? 2'd1 : cf;
    case (ef)
      2'd0: begin eh = turn(cd, hi); el = turn(cd, lo); end
      2'd1: begin eh = 3'b000; el = 3'b111; end
      2'd2: begin eh = 3'b111; el = 3'b000; end
      default: begin eh = 3'b100; el = 3'b100; end
    endcase
    st1 = (hi & lo) != 0;
    st2 = (eh & el) != 0;
    if (co) begin e1 = 0; e2 = 0; end
    else if (cdu) begin e1 = !st1; e2 = !st2; end
    else begin e1 = !(st1 || st2); e2 = 0; end
    check({tag, " gates"}, {2'b00, o_hi, o_lo}, {2'b00, eh, el});
    check({tag, " src"}, {6'd0, s1, s2}, {6'd0, e1, e2});
    if (ef == 2'd0) begin
      // R13 phase sum zero; R4 shorted legs line up
      check("R13 cm", 8'(ones(hi) - ones(o_hi) + 8), 8'd8);
      check("R4 st", {7'd0, (o_hi & o_lo) != 0}, {7'd0, st1});
      // R5 no all-upper against all-lower pairing
      if (hi == 3'b111 && lo == 3'b000)
        check("R5 null", {7'd0, (o_hi == 3'b000 && o_lo == 3'b111)}, 8'd0);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // drive non-default raw settings while in reset: R1 says they are ignored
    dir = 1'b1; flt = 2'b01; dual = 1'b1; ow = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hi = 3'b100; lo = 3'b011;
    #1;
    check("R1 reset gates", {2'b00, o_hi, o_lo}, {2'b00, 3'b010, 3'b101});
    check("R1 reset src", {6'd0, s1, s2}, 8'b10);

    // R2 / R3 spot values
    load_cfg(0, 0, 0, 0);
    hi = 3'b100; lo = 3'b011; #1;
    check("R2 100", {5'd0, o_hi}, 8'b010);
    load_cfg(1, 0, 0, 0);
    hi = 3'b100; lo = 3'b011; #1;
    check("R3 100", {5'd0, o_hi}, 8'b001);

    // R12: change raw inputs without strobe, old setting (dir 1) must hold
    @(negedge clk);
    dir = 0; flt = 2'b10; dual = 1; ow = 1;
    repeat (3) @(negedge clk);
    hi = 3'b100; lo = 3'b011; #1;
    check("R12 hold gates", {2'b00, o_hi, o_lo}, {2'b00, 3'b001, 3'b110});
    check("R12 hold src", {6'd0, s1, s2}, 8'b10);
    // R12: strobe now, short clamp and one-way take effect next cycle
    @(negedge clk); strobe = 1; @(negedge clk); strobe = 0; #1;
    check("R12 take R9", {2'b00, o_hi, o_lo}, {2'b00, 3'b111, 3'b000});
    check("R12 take R7", {6'd0, s1, s2}, 8'b00);

    // Sweep: R2 R3 R4 R6 R7 R8 R9 R10 R11 R13 over every setting and gate pattern
    for (int c = 0; c < 32; c++) begin
      logic cd, cdu, co;
      logic [1:0] cf;
      string tag;
      cd = c[0]; cf = c[2:1]; cdu = c[3]; co = c[4];
      load_cfg(cd, cf, cdu, co);
      case (cf)
        2'd0: tag = cd ? "R3" : "R2";
        2'd1: tag = "R8";
        2'd2: tag = "R9";
        default: tag = "R10";
      endcase
      if (co) tag = {tag, "/R7"};
      else if (cdu) tag = {tag, "/R11"};
      else tag = {tag, "/R6"};
      for (int v = 0; v < 64; v++) begin
        @(negedge clk);
        hi = v[5:3]; lo = v[2:0];
        #1;
        check_vec(cd, cf, cdu, co, tag);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule